// File: doc/BRIEF.md
# Packet Serial Receiver with Idle-Gap Framing

This block receives asynchronous serial characters (one start bit, eight data bits sent least significant bit first, an optional parity bit and one stop bit) and groups them into packets. A packet ends when the line stays idle for a programmed number of bit times. The incoming line is first brought into the clock domain and passed through a glitch filter of programmable length. Each bit is then sampled at its centre. Timing for the centre sample comes from a phase accumulator: a 24-bit increment is added to it on every clock.

Received characters go into a byte queue. When a packet closes, its byte count goes into a second queue. The host drives four word registers: rate at address 0, mode/status at address 1, data at address 2 and packet length at address 3. Reads of the data and length registers pop their queues. A read returns its value on `rd_data` in the cycle after `rd_en` is sampled. Writes take effect at the clock edge where `wr_en` is sampled.

The receiver can optionally treat the line as idle while a local transmitter is driving it, so that it does not hear its own echo. Sticky flags record a false start bit, a missing stop bit, a parity mismatch and a read of the empty data queue.

Top module: `pkt_uart_rx`

## Requirements
- R1: After reset, reads of the rate, mode/status and length registers all return zero, and the receiver is idle.
- R2: Rate bits 23:0 set the phase increment, so one bit time is 2^24/increment clocks. A character is sampled at the centre of each bit and stored with its first data bit in bit 0.
- R3: The filter length in clocks is the 16-bit value {rate[31:24], mode[29:22]}. A low pulse on the line that is shorter than this length is never seen, and it leaves the status unchanged.
- R4: If the filtered line is high again at the centre of a start bit, sticky status bit 0 is set and no character is stored.
- R5: If the stop bit is sampled low, sticky status bit 1 is set and the character is dropped.
- R6: Mode bit 17 enables a parity bit after the data, and mode bit 18 selects odd parity (0 selects even). On a mismatch, sticky status bit 5 is set and the character is still stored.
- R7: A packet ends after mode[15:8] idle bit times, measured from the centre of the last stop bit. Its byte count is pushed to the length queue, and a gap shorter than this keeps the packet open. An idle period that contains no bytes pushes nothing. Status bits 20:16 give the number of queued lengths, and bit 21 is set while that number is nonzero.
- R8: With mode bit 3 clear, no start bit is accepted and nothing is queued.
- R9: With mode bit 2 set, the line is treated as idle while `tx_active` is high. Status bit 6 reads 1 while this masking is in force.
- R10: A read of address 2 pops one byte into bits 7:0. A read when the byte queue is empty returns 0 and sets sticky status bit 30. A read of address 3 pops one packet length.
- R11: A mode write with bits 31 and 16 both set empties both queues, aborts any character being received and leaves the configuration unchanged.
- R12: In a mode write, a 1 in bit 0, 1, 5 or 30 clears that sticky flag.
- R13: Status bit 7 is high while a character is being received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_line | input | 1 | Serial input, idle high |
| tx_active | input | 1 | High while the local transmitter drives the line |
| wr_en | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select for reads and writes |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Register read strobe; data and length reads pop their queues |
| rd_data | output | 32 | Read data, valid the cycle after rd_en |

## Verification
The hardest cases to reach are the timing boundaries between filter and sampler. One is a low pulse long enough to pass the filter but over before the centre of the start bit. Another is an inter-character gap just under the packet-close threshold. The bench reaches these with a bit time of 16 clocks and a filter length of 4. It drives pulses of 3 and 6 clocks, and it inserts a single extra idle bit between characters when the threshold is two bit times.

// File: rtl/pkt_uart_rx_pkg.sv
package pkt_uart_rx_pkg;

    localparam int ACC_W = 24;

    typedef enum logic [1:0] {
        REG_RATE  = 2'd0,
        REG_MODE  = 2'd1,
        REG_DATA  = 2'd2,
        REG_FRAME = 2'd3
    } reg_sel_e;

    typedef enum logic [2:0] {
        ST_HUNT,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP
    } rx_state_e;

    typedef struct packed {
        logic [7:0] filt_lo;
        logic [7:0] gap;
        logic       odd;
        logic       par_en;
        logic       mask_en;
        logic       enable;
    } mode_cfg_t;

    typedef struct packed {
        logic bad_pop;
        logic parity;
        logic no_stop;
        logic false_start;
    } err_flags_t;

    localparam int B_FALSE  = 0;
    localparam int B_NOSTOP = 1;
    localparam int B_MASKEN = 2;
    localparam int B_EN     = 3;
    localparam int B_PARERR = 5;
    localparam int B_MASKED = 6;
    localparam int B_BUSY   = 7;
    localparam int B_CLR_LO = 16;
    localparam int B_PAREN  = 17;
    localparam int B_ODD    = 18;
    localparam int B_FQNE   = 21;
    localparam int B_BADPOP = 30;
    localparam int B_CLR_HI = 31;

    // value the parity bit must carry for a given data byte
    function automatic logic parity_bit(input logic [7:0] d, input logic odd);
        return (^d) ^ odd;
    endfunction

endpackage

// File: rtl/pkt_uart_rx_filter.sv
module pkt_uart_rx_filter #(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             line_in,
    input  logic             tx_active,
    input  logic             mask_en,
    input  logic [LEN_W-1:0] len,
    output logic             line_out,
    output logic             masked
);
    logic [1:0]       sync_q;
    logic [LEN_W-1:0] cnt_q;
    logic             eff;

    // a masked line looks idle
    assign eff = masked ? 1'b1 : sync_q[1];

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q   <= 2'b11;
            masked   <= 1'b0;
            line_out <= 1'b1;
            cnt_q    <= '0;
        end else begin
            sync_q <= {sync_q[0], line_in};
            masked <= mask_en & tx_active;
            if (eff == line_out) begin
                cnt_q <= '0;
            end else if (cnt_q >= len) begin
                line_out <= eff;
                cnt_q    <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/pkt_uart_rx_fifo.sv
module pkt_uart_rx_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 16,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic [CW-1:0] count,
    output logic          empty,
    output logic          full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [CW-1:0] FULL_C = CW'(DEPTH);
    localparam logic [AW-1:0] LAST_C = AW'(DEPTH - 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          push_ok, pop_ok;

    assign empty   = (count == '0);
    assign full    = (count == FULL_C);
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign dout    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= (wr_ptr == LAST_C) ? '0 : wr_ptr + 1'b1;
            if (pop_ok)  rd_ptr <= (rd_ptr == LAST_C) ? '0 : rd_ptr + 1'b1;
            case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/pkt_uart_rx_core.sv
module pkt_uart_rx_core
    import pkt_uart_rx_pkg::*;
#(
    parameter int LEN_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             line,
    input  logic             enable,
    input  logic [ACC_W-1:0] inc,
    input  logic             par_en,
    input  logic             odd,
    input  logic [7:0]       gap,
    input  logic             data_full,
    input  logic             frame_full,
    output logic             byte_push,
    output logic [7:0]       byte_data,
    output logic             frame_push,
    output logic [LEN_W-1:0] frame_len,
    output logic             busy,
    output logic             ev_false_start,
    output logic             ev_no_stop,
    output logic             ev_parity
);
    localparam logic [ACC_W-1:0] HALF_C = ACC_W'(1) << (ACC_W - 1);
    localparam logic [LEN_W-1:0] LEN_MAX = '1;

    rx_state_e        state_q;
    logic [ACC_W-1:0] acc_q;
    logic [ACC_W:0]   sum;
    logic             tick;
    logic             line_q;
    logic [7:0]       shreg_q;
    logic [2:0]       bit_q;
    logic             par_bad_q;
    logic [7:0]       gap_q;
    logic [LEN_W-1:0] bytes_q;

    assign sum  = {1'b0, acc_q} + {1'b0, inc};
    assign tick = sum[ACC_W];
    assign busy = (state_q != ST_HUNT);

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            state_q        <= ST_HUNT;
            acc_q          <= '0;
            line_q         <= 1'b1;
            shreg_q        <= '0;
            bit_q          <= '0;
            par_bad_q      <= 1'b0;
            gap_q          <= '0;
            bytes_q        <= '0;
            byte_push      <= 1'b0;
            byte_data      <= '0;
            frame_push     <= 1'b0;
            frame_len      <= '0;
            ev_false_start <= 1'b0;
            ev_no_stop     <= 1'b0;
            ev_parity      <= 1'b0;
        end else begin
            byte_push      <= 1'b0;
            frame_push     <= 1'b0;
            ev_false_start <= 1'b0;
            ev_no_stop     <= 1'b0;
            ev_parity      <= 1'b0;
            line_q         <= line;
            acc_q          <= sum[ACC_W-1:0];
            case (state_q)
                ST_HUNT: begin
                    if (tick && gap_q != 8'hFF) gap_q <= gap_q + 1'b1;
                    if (bytes_q != '0 && gap_q >= gap) begin
                        frame_push <= !frame_full;
                        frame_len  <= bytes_q;
                        bytes_q    <= '0;
                    end
                    if (enable && line_q && !line) begin
                        acc_q     <= HALF_C;
                        gap_q     <= '0;
                        par_bad_q <= 1'b0;
                        state_q   <= ST_START;
                    end
                end
                ST_START: if (tick) begin
                    if (!line) begin
                        bit_q   <= '0;
                        state_q <= ST_DATA;
                    end else begin
                        ev_false_start <= 1'b1;
                        state_q        <= ST_HUNT;
                    end
                end
                ST_DATA: if (tick) begin
                    shreg_q <= {line, shreg_q[7:1]};
                    bit_q   <= bit_q + 1'b1;
                    if (bit_q == 3'd7) state_q <= par_en ? ST_PAR : ST_STOP;
                end
                ST_PAR: if (tick) begin
                    par_bad_q <= (line != parity_bit(shreg_q, odd));
                    state_q   <= ST_STOP;
                end
                ST_STOP: if (tick) begin
                    state_q <= ST_HUNT;
                    gap_q   <= '0;
                    if (line) begin
                        ev_parity <= par_bad_q;
                        if (!data_full) begin
                            byte_push <= 1'b1;
                            byte_data <= shreg_q;
                            if (bytes_q != LEN_MAX) bytes_q <= bytes_q + 1'b1;
                        end
                    end else begin
                        ev_no_stop <= 1'b1;
                    end
                end
                default: state_q <= ST_HUNT;
            endcase
        end
    end

endmodule

// File: rtl/pkt_uart_rx.sv
module pkt_uart_rx
    import pkt_uart_rx_pkg::*;
#(
    parameter int DATA_DEPTH  = 16,
    parameter int FRAME_DEPTH = 16,
    parameter int LEN_W       = 10
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        rx_line,
    input  logic        tx_active,
    input  logic        wr_en,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] wr_data,
    input  logic        rd_en,
    output logic [31:0] rd_data
);
    localparam int DCNT_W = $clog2(DATA_DEPTH + 1);
    localparam int FCNT_W = $clog2(FRAME_DEPTH + 1);

    logic [31:0]       rate_q;
    mode_cfg_t         cfg_q;
    err_flags_t        err_q;
    reg_sel_e          sel;
    logic              wr_mode, clear_cmd;
    logic              data_pop, frame_pop, data_rd;
    logic              line_filt, masked;
    logic              byte_push, frame_push, busy;
    logic [7:0]        byte_data, data_dout;
    logic [LEN_W-1:0]  frame_len, frame_dout;
    logic [DCNT_W-1:0] data_cnt;
    logic [FCNT_W-1:0] frame_cnt;
    logic              data_empty, data_full, frame_empty, frame_full;
    logic              ev_false_start, ev_no_stop, ev_parity;
    logic [31:0]       status;

    assign sel       = reg_sel_e'(reg_addr);
    assign wr_mode   = wr_en && (sel == REG_MODE);
    assign clear_cmd = wr_mode && wr_data[B_CLR_HI] && wr_data[B_CLR_LO];
    assign data_rd   = rd_en && (sel == REG_DATA);
    assign data_pop  = data_rd && !data_empty;
    assign frame_pop = rd_en && (sel == REG_FRAME) && !frame_empty;

    pkt_uart_rx_filter #(.LEN_W(16)) u_filter (
        .clk       (clk),
        .rst       (rst),
        .line_in   (rx_line),
        .tx_active (tx_active),
        .mask_en   (cfg_q.mask_en),
        .len       ({rate_q[31:24], cfg_q.filt_lo}),
        .line_out  (line_filt),
        .masked    (masked)
    );

    pkt_uart_rx_core #(.LEN_W(LEN_W)) u_core (
        .clk            (clk),
        .rst            (rst),
        .flush          (clear_cmd),
        .line           (line_filt),
        .enable         (cfg_q.enable),
        .inc            (rate_q[ACC_W-1:0]),
        .par_en         (cfg_q.par_en),
        .odd            (cfg_q.odd),
        .gap            (cfg_q.gap),
        .data_full      (data_full),
        .frame_full     (frame_full),
        .byte_push      (byte_push),
        .byte_data      (byte_data),
        .frame_push     (frame_push),
        .frame_len      (frame_len),
        .busy           (busy),
        .ev_false_start (ev_false_start),
        .ev_no_stop     (ev_no_stop),
        .ev_parity      (ev_parity)
    );

    pkt_uart_rx_fifo #(.W(8), .DEPTH(DATA_DEPTH), .CW(DCNT_W)) u_data_q (
        .clk   (clk),
        .rst   (rst),
        .flush (clear_cmd),
        .push  (byte_push),
        .din   (byte_data),
        .pop   (data_pop),
        .dout  (data_dout),
        .count (data_cnt),
        .empty (data_empty),
        .full  (data_full)
    );

    pkt_uart_rx_fifo #(.W(LEN_W), .DEPTH(FRAME_DEPTH), .CW(FCNT_W)) u_frame_q (
        .clk   (clk),
        .rst   (rst),
        .flush (clear_cmd),
        .push  (frame_push),
        .din   (frame_len),
        .pop   (frame_pop),
        .dout  (frame_dout),
        .count (frame_cnt),
        .empty (frame_empty),
        .full  (frame_full)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rate_q <= '0;
            cfg_q  <= '0;
            err_q  <= '0;
        end else begin
            if (wr_en && sel == REG_RATE) rate_q <= wr_data;
            if (wr_mode && !clear_cmd) begin
                cfg_q.filt_lo <= wr_data[29:22];
                cfg_q.gap     <= wr_data[15:8];
                cfg_q.odd     <= wr_data[B_ODD];
                cfg_q.par_en  <= wr_data[B_PAREN];
                cfg_q.mask_en <= wr_data[B_MASKEN];
                cfg_q.enable  <= wr_data[B_EN];
                if (wr_data[B_FALSE])  err_q.false_start <= 1'b0;
                if (wr_data[B_NOSTOP]) err_q.no_stop     <= 1'b0;
                if (wr_data[B_PARERR]) err_q.parity      <= 1'b0;
                if (wr_data[B_BADPOP]) err_q.bad_pop     <= 1'b0;
            end
            if (ev_false_start)         err_q.false_start <= 1'b1;
            if (ev_no_stop)             err_q.no_stop     <= 1'b1;
            if (ev_parity)              err_q.parity      <= 1'b1;
            if (data_rd && data_empty)  err_q.bad_pop     <= 1'b1;
        end
    end

    always_comb begin
        status           = '0;
        status[B_FALSE]  = err_q.false_start;
        status[B_NOSTOP] = err_q.no_stop;
        status[B_MASKEN] = cfg_q.mask_en;
        status[B_EN]     = cfg_q.enable;
        status[B_PARERR] = err_q.parity;
        status[B_MASKED] = masked;
        status[B_BUSY]   = busy;
        status[15:8]     = cfg_q.gap;
        status[20:16]    = 5'(frame_cnt);
        status[B_FQNE]   = !frame_empty;
        status[29:22]    = cfg_q.filt_lo;
        status[B_BADPOP] = err_q.bad_pop;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
        end else if (rd_en) begin
            case (sel)
                REG_RATE:  rd_data <= rate_q;
                REG_MODE:  rd_data <= status;
                REG_DATA:  rd_data <= data_empty ? 32'd0 : 32'(data_dout);
                REG_FRAME: rd_data <= frame_empty ? 32'd0 : 32'(frame_dout);
                default:   rd_data <= '0;
            endcase
        end
    end

endmodule

// File: rtl/pkt_uart_rx_chk.sv
module pkt_uart_rx_chk #(
    parameter int LEN_W = 10
) (
    input logic             clk,
    input logic             rst,
    input logic             clear_cmd,
    input logic             data_empty,
    input logic             frame_empty,
    input logic             frame_push,
    input logic [LEN_W-1:0] frame_len,
    input logic             enable,
    input logic             busy,
    input logic             rd_en,
    input logic [1:0]       reg_addr,
    input logic [31:0]      rd_data,
    input logic             bad_pop,
    input logic             ev_no_stop,
    input logic             byte_push,
    input logic             masked,
    input logic             line_filt
);
    assert_clear_empties_R11: assert property (@(posedge clk) disable iff (rst)
        clear_cmd |=> (data_empty && frame_empty));

    assert_no_empty_packet_R7: assert property (@(posedge clk) disable iff (rst)
        frame_push |-> (frame_len != '0));

    assert_idle_when_disabled_R8: assert property (@(posedge clk) disable iff (rst)
        (!enable && !busy) |=> !busy);

    assert_empty_read_flags_R10: assert property (@(posedge clk) disable iff (rst)
        (rd_en && reg_addr == 2'd2 && data_empty) |=> (bad_pop && rd_data == 32'd0));

    assert_missing_stop_drops_R5: assert property (@(posedge clk) disable iff (rst)
        ev_no_stop |-> !byte_push);

    assert_mask_holds_idle_R9: assert property (@(posedge clk) disable iff (rst)
        (masked && $past(masked)) |-> !$fell(line_filt));

endmodule

bind pkt_uart_rx pkt_uart_rx_chk #(.LEN_W(LEN_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .clear_cmd   (clear_cmd),
    .data_empty  (data_empty),
    .frame_empty (frame_empty),
    .frame_push  (frame_push),
    .frame_len   (frame_len),
    .enable      (cfg_q.enable),
    .busy        (busy),
    .rd_en       (rd_en),
    .reg_addr    (reg_addr),
    .rd_data     (rd_data),
    .bad_pop     (err_q.bad_pop),
    .ev_no_stop  (ev_no_stop),
    .byte_push   (byte_push),
    .masked      (masked),
    .line_filt   (line_filt)
);

// File: tb/pkt_uart_rx_tb.sv
module pkt_uart_rx_tb;
    localparam int CLK_PERIOD = 10;
    localparam int BIT_CLKS   = 16;
    localparam logic [31:0] RATE = 32'h0010_0000;  // 2^24/16
    localparam logic [31:0] BASE = 32'h0100_0208;  // filter 4, gap 2, enable

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rx_line = 1'b1;
    logic        tx_active = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [31:0] rd_data;

    int n_checks = 0;
    int n_errors = 0;
    logic [7:0] exp_bytes[$];
    int         exp_lens[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    pkt_uart_rx u_dut (
        .clk       (clk),
        .rst       (rst),
        .rx_line   (rx_line),
        .tx_active (tx_active),
        .wr_en     (wr_en),
        .reg_addr  (reg_addr),
        .wr_data   (wr_data),
        .rd_en     (rd_en),
        .rd_data   (rd_data)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; reg_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1; reg_addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    function automatic logic [31:0] exp_status(input logic [31:0] cfg, input int fcnt,
                                               input logic [31:0] extra);
        logic [31:0] s;
        s = cfg & ~32'h001F_0000;
        s[20:16] = 5'(fcnt);
        s[21] = (fcnt != 0);
        return s | extra;
    endfunction

    task automatic drive_bit(input logic v);
        rx_line = v;
        repeat (BIT_CLKS) @(negedge clk);
    endtask

    // driver: sends one character and records what should be stored
    task automatic send_frame(input logic [7:0] b, input bit use_par, input bit par_bit,
                              input bit stop_bit, input bit expect_store);
        drive_bit(1'b0);
        for (int i = 0; i < 8; i++) drive_bit(b[i]);
        if (use_par) drive_bit(par_bit);
        drive_bit(stop_bit);
        rx_line = 1'b1;
        if (expect_store) exp_bytes.push_back(b);
    endtask

    task automatic end_packet(input int n);
        exp_lens.push_back(n);
        repeat (6 * BIT_CLKS) @(negedge clk);
    endtask

    // monitor: pops length and data queues and compares with expectations
    task automatic monitor(input string req);
        logic [31:0] d;
        int len;
        while (exp_lens.size() != 0) begin
            len = exp_lens.pop_front();
            reg_read(2'd3, d);
            chk({req, " length"}, d, 32'(len));
            for (int i = 0; i < len; i++) begin
                reg_read(2'd2, d);
                chk({req, " byte"}, d, 32'(exp_bytes.pop_front()));
            end
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

    initial begin
        logic [31:0] d;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1 reset values
        reg_read(2'd0, d); chk("R1 rate", d, 32'd0);
        reg_read(2'd1, d); chk("R1 status", d, 32'd0);
        reg_read(2'd3, d); chk("R1 length", d, 32'd0);

        reg_write(2'd0, RATE);
        reg_write(2'd1, BASE);
        repeat (3 * BIT_CLKS) @(negedge clk);

        // R2 R13: three-byte packet, busy seen mid-character
        fork
            begin
                send_frame(8'hA5, 0, 0, 1, 1);
                send_frame(8'h3C, 0, 0, 1, 1);
                send_frame(8'h81, 0, 0, 1, 1);
            end
            begin
                repeat (40) @(negedge clk);
                reg_read(2'd1, d);
                chk("R13 busy", d, exp_status(BASE, 0, 32'h80));
            end
        join
        end_packet(3);
        reg_read(2'd1, d); chk("R7 one packet queued", d, exp_status(BASE, 1, 0));
        monitor("R2");

        // R7 two packets, plus a short gap that keeps one packet open
        send_frame(8'h11, 0, 0, 1, 1);
        send_frame(8'hE7, 0, 0, 1, 1);
        end_packet(2);
        send_frame(8'h42, 0, 0, 1, 1);
        end_packet(1);
        send_frame(8'h0F, 0, 0, 1, 1);
        drive_bit(1'b1);
        send_frame(8'hF0, 0, 0, 1, 1);
        end_packet(2);
        reg_read(2'd1, d); chk("R7 three packets", d, exp_status(BASE, 3, 0));
        monitor("R7");
        reg_read(2'd1, d); chk("R7 queue drained", d, exp_status(BASE, 0, 0));

        // R3 short glitch is invisible
        rx_line = 1'b0; repeat (3) @(negedge clk); rx_line = 1'b1;
        repeat (2 * BIT_CLKS) @(negedge clk);
        reg_read(2'd1, d); chk("R3 glitch", d, exp_status(BASE, 0, 0));

        // R4 false start
        rx_line = 1'b0; repeat (6) @(negedge clk); rx_line = 1'b1;
        repeat (2 * BIT_CLKS) @(negedge clk);
        reg_read(2'd1, d); chk("R4 false start", d, exp_status(BASE, 0, 32'h1));
        reg_write(2'd1, BASE | 32'h1);
        reg_read(2'd1, d); chk("R12 clear bit0", d, exp_status(BASE, 0, 0));

        // R5 missing stop bit
        send_frame(8'h55, 0, 0, 0, 0);
        repeat (6 * BIT_CLKS) @(negedge clk);
        reg_read(2'd1, d); chk("R5 no stop", d, exp_status(BASE, 0, 32'h2));

        // R10 empty data read
        reg_read(2'd2, d); chk("R10 empty read value", d, 32'd0);
        reg_read(2'd1, d); chk("R10 bad pop flag", d, exp_status(BASE, 0, 32'h4000_0002));
        reg_write(2'd1, BASE | 32'h4000_0002);
        reg_read(2'd1, d); chk("R12 clear bits 1 and 30", d, exp_status(BASE, 0, 0));

        // R6 even parity: good then bad
        reg_write(2'd1, BASE | 32'h2_0000);
        send_frame(8'h03, 1, 0, 1, 1);
        end_packet(1);
        reg_read(2'd1, d); chk("R6 even ok", d, exp_status(BASE | 32'h2_0000, 1, 0));
        send_frame(8'h07, 1, 0, 1, 1);
        end_packet(1);
        reg_read(2'd1, d); chk("R6 even bad", d, exp_status(BASE | 32'h2_0000, 2, 32'h20));
        monitor("R6 even");
        reg_write(2'd1, BASE | 32'h2_0020);
        reg_read(2'd1, d); chk("R12 clear bit5", d, exp_status(BASE | 32'h2_0000, 0, 0));
        reg_write(2'd1, BASE | 32'h6_0000);
        send_frame(8'h07, 1, 0, 1, 1);
        end_packet(1);
        reg_read(2'd1, d); chk("R6 odd ok", d, exp_status(BASE | 32'h6_0000, 1, 0));
        monitor("R6 odd");

        // R9 masking while transmitting
        reg_write(2'd1, BASE | 32'h4);
        tx_active = 1'b1;
        repeat (4) @(negedge clk);
        reg_read(2'd1, d); chk("R9 mask state", d, exp_status(BASE | 32'h4, 0, 32'h40));
        send_frame(8'h99, 0, 0, 1, 0);
        repeat (6 * BIT_CLKS) @(negedge clk);
        reg_read(2'd1, d); chk("R9 masked ignored", d, exp_status(BASE | 32'h4, 0, 32'h40));
        tx_active = 1'b0;
        repeat (4) @(negedge clk);
        send_frame(8'h5A, 0, 0, 1, 1);
        end_packet(1);
        reg_read(2'd1, d); chk("R9 unmasked", d, exp_status(BASE | 32'h4, 1, 0));
        monitor("R9");

        // R8 receiver disabled
        reg_write(2'd1, BASE & ~32'h8);
        send_frame(8'h66, 0, 0, 1, 0);
        repeat (6 * BIT_CLKS) @(negedge clk);
        reg_read(2'd1, d); chk("R8 disabled", d, exp_status(BASE & ~32'h8, 0, 0));
        reg_read(2'd3, d); chk("R8 no length", d, 32'd0);

        // R11 clear command
        reg_write(2'd1, BASE);
        send_frame(8'h33, 0, 0, 1, 0);
        send_frame(8'h44, 0, 0, 1, 0);
        repeat (6 * BIT_CLKS) @(negedge clk);
        reg_read(2'd1, d); chk("R11 before clear", d, exp_status(BASE, 1, 0));
        reg_write(2'd1, 32'h8001_0000);
        reg_read(2'd1, d); chk("R11 after clear", d, exp_status(BASE, 0, 0));
        reg_read(2'd2, d); chk("R11 data gone", d, 32'd0);
        reg_read(2'd0, d); chk("R2 rate readback", d, RATE);

        $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

endmodule